// File: doc/BRIEF.md
# Supply Rail Power-Up Sequencer

This block brings up a chain of supply regulators in one fixed order and then lets the processor out of reset. It watches five raw good flags: the main switching output above its undervoltage threshold, the 5 V system rail, and three LDO rails (I/O, analog and core). It drives the enable of the medium-voltage buck, the enables of the three LDOs, and a power-on-reset release line. Every delay is counted in ticks of an external timebase strobe, and each delay is a parameter.

Each raw flag first passes a blanking filter, so that short glitches never reach the control logic. The sequence runs in this order: main rail good, delay, buck on, system rail good, delay, I/O LDO on, delay, analog LDO on, delay, core LDO on, delay, a combined LDO check, a final delay, and then reset release. Once the processor runs, the loss of any of the four lower rails pulls the reset line again. The reset is released once more only after all four rails have been good for a full reset interval.

Dropping the main enable input shuts the chain down. The reset line goes low first, and then the LDOs and the buck turn off in reverse order, one per tick. The sequencer then returns to idle.

Top module: `rail_seq_top`

## Requirements
- R1: While reset is held, and in the first cycle after it, all five outputs are low.
- R2: A raw flag changes its filtered value only after the new level has been seen on BLANK_TICKS consecutive ticks. A shorter pulse leaves every output unchanged.
- R3: Nothing starts while main_en is low. With main_en high and the filtered main flag good, buck_en rises on the DLY_BUCK-th tick after that condition.
- R4: With the buck on, io_ldo_en rises on the DLY_STEP-th tick after the filtered system flag is good.
- R5: ana_ldo_en rises DLY_STEP ticks after io_ldo_en, and core_ldo_en rises DLY_STEP ticks after ana_ldo_en.
- R6: DLY_STEP ticks after core_ldo_en, the three filtered LDO flags are sampled. If all are good, por_rel rises DLY_POR ticks later.
- R7: If that sample fails, the sample repeats every DLY_STEP ticks, and por_rel stays low until a sample passes.
- R8: The enables are nested: io needs buck, analog needs io, core needs analog, and por_rel needs core. No two outputs change in the same cycle.
- R9: While waiting for release or while running, a filtered low on the system, I/O, analog or core flag drops por_rel in the next cycle. All enables stay high.
- R10: After such a fault, por_rel rises again once all four filtered flags have been good for DLY_RST ticks in a row.
- R11: When main_en goes low, por_rel is low in the next cycle. Core, analog, I/O and buck enables then clear in that order, one per tick, and a later main_en restarts the whole sequence.
- R12: Enables change only in the cycle after a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle timebase strobe |
| main_en | input | 1 | Enable for the main rail; low shuts the chain down |
| main_ok | input | 1 | Raw: main switching output above its rising threshold |
| sys_ok | input | 1 | Raw: 5 V system rail good |
| io_ok | input | 1 | Raw: I/O LDO good |
| ana_ok | input | 1 | Raw: analog LDO good |
| core_ok | input | 1 | Raw: core LDO good |
| buck_en | output | 1 | Medium-voltage buck enable |
| io_ldo_en | output | 1 | I/O LDO enable |
| ana_ldo_en | output | 1 | Analog LDO enable |
| core_ldo_en | output | 1 | Core LDO enable |
| por_rel | output | 1 | Processor reset release (high = run) |

## Verification
The assertions check the following on every cycle:
- the nesting of enables and reset release;
- that at most one output changes per cycle;
- that enables and filtered flags move only after a tick;
- that a filtered rail loss or a low main_en drops the reset line in the next cycle;
- that the enable count never grows during shutdown.

The exact number of ticks per step is shown only by the bench scenarios:
- each step lands on its tick count, and not one tick earlier;
- a failed LDO check delays release to the next re-sample point;
- random glitches shorter than the blanking window leave the outputs untouched;
- recovery waits the full reset interval;
- a restart follows a complete reverse-order shutdown.

// File: rtl/rseq_pkg.sv
package rseq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_BUCK_DLY,
        ST_SYS_WAIT,
        ST_IO_DLY,
        ST_ANA_DLY,
        ST_CORE_DLY,
        ST_CHECK,
        ST_POR_DLY,
        ST_RUN,
        ST_FAULT,
        ST_SHUT
    } seq_state_e;

    // flag positions in the filtered vector
    localparam int FL_MAIN  = 0;
    localparam int FL_SYS   = 1;
    localparam int FL_IO    = 2;
    localparam int FL_ANA   = 3;
    localparam int FL_CORE  = 4;
    localparam int NUM_FLAGS = 5;

    // enable positions: 0 buck, 1 io, 2 analog, 3 core
    localparam int NUM_EN = 4;

    typedef struct packed {
        seq_state_e          st;
        logic [NUM_EN-1:0]   en;
        logic                por;
    } seq_reg_t;

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/rseq_blank.sv
module rseq_blank #(
    parameter int W           = 5,
    parameter int BLANK_TICKS = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] raw,
    output logic [W-1:0] filt
);
    localparam int CW = $clog2(BLANK_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(BLANK_TICKS - 1);

    typedef struct packed {
        logic [W-1:0]          filt;
        logic [W-1:0][CW-1:0]  cnt;
    } blank_reg_t;

    blank_reg_t blk_d, blk_q;

    always_comb begin
        blk_d = blk_q;
        if (tick) begin
            for (int i = 0; i < W; i++) begin
                if (raw[i] == blk_q.filt[i]) begin
                    blk_d.cnt[i] = '0;
                end else if (blk_q.cnt[i] == LAST) begin
                    blk_d.filt[i] = raw[i];
                    blk_d.cnt[i]  = '0;
                end else begin
                    blk_d.cnt[i] = blk_q.cnt[i] + CW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) blk_q <= '0;
        else        blk_q <= blk_d;
    end

    assign filt = blk_q.filt;

endmodule

// File: rtl/rseq_timer.sv
module rseq_timer #(
    parameter int TW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          clr,
    input  logic [TW-1:0] limit,
    output logic          expire
);
    logic [TW-1:0] cnt_d, cnt_q;
    logic          at_last;

    assign at_last = (cnt_q == limit - TW'(1));
    assign expire  = tick && at_last;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)          cnt_d = '0;
        else if (expire)  cnt_d = '0;
        else if (tick)    cnt_d = cnt_q + TW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/rseq_fsm.sv
module rseq_fsm
    import rseq_pkg::*;
#(
    parameter int TW        = 3,
    parameter int DLY_BUCK  = 4,
    parameter int DLY_STEP  = 2,
    parameter int DLY_POR   = 4,
    parameter int DLY_RST   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 main_en,
    input  logic [NUM_FLAGS-1:0] good,
    input  logic                 expire,
    output logic                 tmr_clr,
    output logic [TW-1:0]        limit,
    output logic [NUM_EN-1:0]    en,
    output logic                 por
);
    seq_reg_t seq_d, seq_q;
    logic     rails_ok;
    logic     ldos_ok;
    logic     hold_clr;

    assign rails_ok = good[FL_SYS] & good[FL_IO] & good[FL_ANA] & good[FL_CORE];
    assign ldos_ok  = good[FL_IO] & good[FL_ANA] & good[FL_CORE];

    always_comb begin
        seq_d    = seq_q;
        limit    = TW'(DLY_STEP);
        hold_clr = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                seq_d.en  = '0;
                seq_d.por = 1'b0;
                if (main_en && good[FL_MAIN]) seq_d.st = ST_BUCK_DLY;
            end
            ST_BUCK_DLY: begin
                limit = TW'(DLY_BUCK);
                if (expire) begin
                    seq_d.en[0] = 1'b1;
                    seq_d.st    = ST_SYS_WAIT;
                end
            end
            ST_SYS_WAIT: begin
                if (good[FL_SYS]) seq_d.st = ST_IO_DLY;
            end
            ST_IO_DLY: begin
                if (expire) begin
                    seq_d.en[1] = 1'b1;
                    seq_d.st    = ST_ANA_DLY;
                end
            end
            ST_ANA_DLY: begin
                if (expire) begin
                    seq_d.en[2] = 1'b1;
                    seq_d.st    = ST_CORE_DLY;
                end
            end
            ST_CORE_DLY: begin
                if (expire) begin
                    seq_d.en[3] = 1'b1;
                    seq_d.st    = ST_CHECK;
                end
            end
            ST_CHECK: begin
                // a failed sample lets the timer wrap and try again
                if (expire && ldos_ok) seq_d.st = ST_POR_DLY;
            end
            ST_POR_DLY: begin
                limit = TW'(DLY_POR);
                if (!rails_ok) begin
                    seq_d.st = ST_FAULT;
                end else if (expire) begin
                    seq_d.por = 1'b1;
                    seq_d.st  = ST_RUN;
                end
            end
            ST_RUN: begin
                if (!rails_ok) begin
                    seq_d.por = 1'b0;
                    seq_d.st  = ST_FAULT;
                end
            end
            ST_FAULT: begin
                limit = TW'(DLY_RST);
                if (!rails_ok) begin
                    hold_clr = 1'b1;
                end else if (expire) begin
                    seq_d.por = 1'b1;
                    seq_d.st  = ST_RUN;
                end
            end
            ST_SHUT: begin
                if (tick) begin
                    if (seq_q.en[3])      seq_d.en[3] = 1'b0;
                    else if (seq_q.en[2]) seq_d.en[2] = 1'b0;
                    else if (seq_q.en[1]) seq_d.en[1] = 1'b0;
                    else if (seq_q.en[0]) seq_d.en[0] = 1'b0;
                    else                  seq_d.st    = ST_IDLE;
                end
            end
            default: begin
                seq_d.st  = ST_IDLE;
                seq_d.en  = '0;
                seq_d.por = 1'b0;
            end
        endcase

        if (!main_en && seq_q.st != ST_IDLE && seq_q.st != ST_SHUT) begin
            seq_d.st  = ST_SHUT;
            seq_d.en  = seq_q.en;
            seq_d.por = 1'b0;
        end
    end

    assign tmr_clr = hold_clr || (seq_d.st != seq_q.st);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: ST_IDLE, en: '0, por: 1'b0};
        else        seq_q <= seq_d;
    end

    assign en  = seq_q.en;
    assign por = seq_q.por;

endmodule

// File: rtl/rail_seq_top.sv
module rail_seq_top
    import rseq_pkg::*;
#(
    parameter int BLANK_TICKS = 2,
    parameter int DLY_BUCK    = 4,
    parameter int DLY_STEP    = 2,
    parameter int DLY_POR     = 4,
    parameter int DLY_RST     = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic main_en,
    input  logic main_ok,
    input  logic sys_ok,
    input  logic io_ok,
    input  logic ana_ok,
    input  logic core_ok,
    output logic buck_en,
    output logic io_ldo_en,
    output logic ana_ldo_en,
    output logic core_ldo_en,
    output logic por_rel
);
    localparam int MAX_DLY = max4(DLY_BUCK, DLY_STEP, DLY_POR, DLY_RST);
    localparam int TW      = $clog2(MAX_DLY + 1);

    logic [NUM_FLAGS-1:0] raw_vec;
    logic [NUM_FLAGS-1:0] good_f;
    logic [NUM_EN-1:0]    en_vec;
    logic                 tmr_clr;
    logic                 tmr_exp;
    logic [TW-1:0]        tmr_lim;

    assign raw_vec = {core_ok, ana_ok, io_ok, sys_ok, main_ok};

    rseq_blank #(
        .W           (NUM_FLAGS),
        .BLANK_TICKS (BLANK_TICKS)
    ) u_blank (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .raw   (raw_vec),
        .filt  (good_f)
    );

    rseq_timer #(
        .TW (TW)
    ) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .clr    (tmr_clr),
        .limit  (tmr_lim),
        .expire (tmr_exp)
    );

    rseq_fsm #(
        .TW       (TW),
        .DLY_BUCK (DLY_BUCK),
        .DLY_STEP (DLY_STEP),
        .DLY_POR  (DLY_POR),
        .DLY_RST  (DLY_RST)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .main_en (main_en),
        .good    (good_f),
        .expire  (tmr_exp),
        .tmr_clr (tmr_clr),
        .limit   (tmr_lim),
        .en      (en_vec),
        .por     (por_rel)
    );

    assign buck_en     = en_vec[0];
    assign io_ldo_en   = en_vec[1];
    assign ana_ldo_en  = en_vec[2];
    assign core_ldo_en = en_vec[3];

endmodule

// File: rtl/rseq_chk.sv
module rseq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       main_en,
    input logic [4:0] good_f,
    input logic [3:0] en,
    input logic       por
);
    // R8: enables nested, release only with core on
    a_r8_nested: assert property (@(posedge clk) disable iff (!rst_n)
        (!en[1] || en[0]) && (!en[2] || en[1]) && (!en[3] || en[2]) && (!por || en[3]));

    // R8: one output change per cycle at most
    a_r8_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({por, en} ^ $past({por, en})) <= 1);

    // R12: enables move only after a tick
    a_r12_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (en != $past(en)) |-> $past(tick));

    // R2: filtered flags move only after a tick
    a_r2_filt_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (good_f != $past(good_f)) |-> $past(tick));

    // R6: release only when all four lower rails were good
    a_r6_release_good: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(por) |-> $past(&good_f[4:1]));

    // R9: rail loss while running drops release next cycle
    a_r9_fault_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (por && !(&good_f[4:1])) |=> !por);

    // R11: main disable drops release and never adds an enable
    a_r11_por_off: assert property (@(posedge clk) disable iff (!rst_n)
        !main_en |=> !por);

    a_r11_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
        !main_en |=> ($countones(en) <= $countones($past(en))));

endmodule

bind rail_seq_top rseq_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .main_en (main_en),
    .good_f  (good_f),
    .en      (en_vec),
    .por     (por_rel)
);

// File: tb/sim_rail_seq_top.sv
`timescale 1ns/1ps
module sim_rail_seq_top;
    localparam int BLK = 2;
    localparam int DB  = 4;
    localparam int DS  = 2;
    localparam int DP  = 4;
    localparam int DR  = 3;
    localparam int TP  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic main_en = 1'b0, main_ok = 1'b0, sys_ok = 1'b0;
    logic io_ok = 1'b0, ana_ok = 1'b0, core_ok = 1'b0;
    logic buck_en, io_ldo_en, ana_ldo_en, core_ldo_en, por_rel;
    int   n_chk = 0, n_bad = 0;
    int   tcnt = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    always_ff @(posedge clk) begin
        tcnt <= (tcnt == TP - 1) ? 0 : tcnt + 1;
        tick <= (tcnt == TP - 1);
    end

    rail_seq_top #(
        .BLANK_TICKS (BLK), .DLY_BUCK (DB), .DLY_STEP (DS),
        .DLY_POR (DP), .DLY_RST (DR)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .tick (tick), .main_en (main_en),
        .main_ok (main_ok), .sys_ok (sys_ok), .io_ok (io_ok),
        .ana_ok (ana_ok), .core_ok (core_ok), .buck_en (buck_en),
        .io_ldo_en (io_ldo_en), .ana_ldo_en (ana_ldo_en),
        .core_ldo_en (core_ldo_en), .por_rel (por_rel)
    );

    // expected output vector {por, core, ana, io, buck} after k steps
    function automatic logic [4:0] stage(input int k);
        return 5'((1 << k) - 1);
    endfunction

    // ticks from a late core-good raise to the first passing sample
    function automatic int late_sample();
        return (BLK / DS + 1) * DS;
    endfunction

    function automatic logic [4:0] outs();
        return {por_rel, core_ldo_en, ana_ldo_en, io_ldo_en, buck_en};
    endfunction

    task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%b exp=%b", req, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            while (!tick) @(negedge clk);
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic set_rail(input int r, input logic v);
        case (r)
            1: sys_ok  = v;
            2: io_ok   = v;
            3: ana_ok  = v;
            default: core_ok = v;
        endcase
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (5) @(negedge clk);
        chk("R1 in reset", outs(), 5'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", outs(), 5'b0);

        // flags good but main_en low: nothing starts
        main_ok = 1'b1; io_ok = 1'b1; ana_ok = 1'b1; core_ok = 1'b1;
        wait_ticks(4);
        chk("R3 no start without main_en", outs(), 5'b0);

        main_en = 1'b1;
        wait_ticks(DB - 1);
        chk("R3/R12 buck not early", outs(), stage(0));
        wait_ticks(1);
        chk("R3 buck on", outs(), stage(1));
        wait_ticks(3);
        chk("R4 waits for system rail", outs(), stage(1));

        sys_ok = 1'b1;
        wait_ticks(BLK + DS - 1);
        chk("R4/R12 io not early", outs(), stage(1));
        wait_ticks(1);
        chk("R4 io on", outs(), stage(2));
        wait_ticks(DS - 1);
        chk("R5 analog not early", outs(), stage(2));
        wait_ticks(1);
        chk("R5 analog on", outs(), stage(3));
        wait_ticks(DS - 1);
        chk("R5 core not early", outs(), stage(3));
        wait_ticks(1);
        chk("R5 core on", outs(), stage(4));
        wait_ticks(DS + DP - 1);
        chk("R6 release not early", outs(), stage(4));
        wait_ticks(1);
        chk("R6/R8 released", outs(), stage(5));

        // short glitches are blanked
        for (int g = 0; g < 16; g++) begin
            int r, w;
            r = 1 + int'($urandom % 4);
            w = 1 + int'($urandom % (TP - 1));
            set_rail(r, 1'b0);
            repeat (w) @(negedge clk);
            set_rail(r, 1'b1);
            repeat (TP * BLK) @(negedge clk);
            chk("R2 glitch ignored", outs(), stage(5));
        end

        // sustained loss and recovery
        for (int f = 0; f < 4; f++) begin
            int r;
            r = 1 + int'($urandom % 4);
            set_rail(r, 1'b0);
            wait_ticks(BLK - 1);
            chk("R2 loss still blanked", outs(), stage(5));
            wait_ticks(1);
            chk("R9 reset on rail loss", outs(), stage(4));
            set_rail(r, 1'b1);
            wait_ticks(BLK + DR - 1);
            chk("R10 recovery not early", outs(), stage(4));
            wait_ticks(1);
            chk("R10 released again", outs(), stage(5));
        end

        // shutdown in reverse order
        main_en = 1'b0;
        repeat (2) @(negedge clk);
        chk("R11 reset first", outs(), stage(4));
        wait_ticks(1);
        chk("R11 core off", outs(), stage(3));
        wait_ticks(1);
        chk("R11 analog off", outs(), stage(2));
        wait_ticks(1);
        chk("R11 io off", outs(), stage(1));
        wait_ticks(1);
        chk("R11 buck off", outs(), stage(0));

        sys_ok = 1'b0; core_ok = 1'b0;
        wait_ticks(3);
        chk("R11 idle", outs(), stage(0));

        // restart with a late core rail
        main_en = 1'b1;
        wait_ticks(DB - 1);
        chk("R3 restart not early", outs(), stage(0));
        wait_ticks(1);
        chk("R3 restart buck on", outs(), stage(1));
        sys_ok = 1'b1;
        wait_ticks(BLK + DS);
        chk("R4 restart io on", outs(), stage(2));
        wait_ticks(DS);
        chk("R5 restart analog on", outs(), stage(3));
        wait_ticks(DS);
        chk("R5 restart core on", outs(), stage(4));
        core_ok = 1'b1;
        wait_ticks(late_sample() + DP - 1);
        chk("R7 release waits for resample", outs(), stage(4));
        wait_ticks(1);
        chk("R7 released after resample", outs(), stage(5));

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule